// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core in which every instruction fetches, decodes, executes, touches memory and writes back within one clock period. It runs a small instruction subset: five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), a word load, a word store and a branch taken when two registers are equal. The core contains the program counter, a 32-entry register file with two combinational read ports and one write port, a two-level decoder, the ALU and the branch-target adder. Instruction and data memory are word arrays inside the block.

Control is decoded in two steps. The main decoder turns the 6-bit opcode into the datapath selects and a 2-bit ALU class. A second decoder combines that class with the 6-bit function field to form the 3-bit ALU operation code. The memories are filled through a word-indexed load port while the core is held in reset. A peek port reads data memory combinationally so results can be inspected. The register write-back and the store of each cycle are also visible on output ports.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register becomes 0. No register or data-memory write from an instruction takes place while `rst` is high.
- R2: Register-type instructions use opcode 000000, with rs in [25:21], rt in [20:16], rd in [15:11] and funct in [5:0]. They write R[rs] OP R[rt] into R[rd], where funct 100000 is add, 100010 is subtract, 100100 is and, 100101 is or and 101010 is signed set-less-than (result 1 or 0). The PC then advances by 4.
- R3: Load (opcode 100011) writes the data word at byte address R[rs] + sign-extended imm[15:0] into R[rt]. The word index is address bits [MEM_AW+1:2], and negative offsets are allowed.
- R4: Store (opcode 101011) writes R[rt] to the data word at R[rs] + sign-extended immediate and writes no register.
- R5: Branch-if-equal (opcode 000100) sets the next PC to PC+4+(sign-extended immediate << 2) when R[rs] equals R[rt], and to PC+4 otherwise. It writes no register and no memory.
- R6: Register 0 reads as zero and ignores writes.
- R7: Any other opcode is a no-op: no register write, no memory write, and the PC advances by 4.
- R8: Register reads are combinational, so an instruction sees the result written by the previous instruction. It may also read and write the same register in one cycle, reading the old value.
- R9: `wb_en`, `wb_reg` and `wb_data` show the register write taking effect at the next edge. `wb_en` is low when the destination is register 0. `mem_we`, `mem_addr` and `mem_wdata` show the store in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one preload word at the next edge |
| load_to_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| load_idx | input | MEM_AW | Preload word index |
| load_data | input | 32 | Preload word |
| peek_idx | input | MEM_AW | Data-memory word index to observe |
| peek_data | output | 32 | Data-memory word at `peek_idx` |
| pc_out | output | 32 | Current program counter |
| instr_out | output | 32 | Instruction being executed |
| wb_en | output | 1 | Register write at the next edge |
| wb_reg | output | 5 | Destination register |
| wb_data | output | 32 | Value written |
| mem_we | output | 1 | Data-memory store at the next edge |
| mem_addr | output | 32 | Store byte address |
| mem_wdata | output | 32 | Store data |

## Verification
Several properties are checked on every cycle: the PC steps by 4 unless a branch is taken, and a taken branch lands on its computed target. Register 0 always reads zero, stores and branches never write a register, and unknown opcodes write nothing. At most one instruction class is decoded. The correctness of each ALU operation's value, the load and store addressing with negative offsets, and the effect of register writes on later instructions can only be shown by the bench's programs. The same holds for reset clearing the register file. These programs check data memory and the PC trace against values worked out from the instruction encodings.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [1:0] CLS_ADD   = 2'b00;
  localparam logic [1:0] CLS_SUB   = 2'b01;
  localparam logic [1:0] CLS_FUNCT = 2'b10;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic [1:0] alu_class;
    logic       known;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input logic [2:0] op,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc4,
                                                   input logic [XLEN-1:0] off);
    return pc4 + {off[XLEN-3:0], 2'b00};
  endfunction
endpackage

// File: rtl/sc_ctrl_main.sv
module sc_ctrl_main
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.alu_class = CLS_FUNCT;
        ctrl.known     = 1'b1;
      end
      OP_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_write   = 1'b1;
        ctrl.mem_read    = 1'b1;
        ctrl.alu_class   = CLS_ADD;
        ctrl.known       = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.alu_class = CLS_ADD;
        ctrl.known     = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch    = 1'b1;
        ctrl.alu_class = CLS_SUB;
        ctrl.known     = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_ctrl_alu.sv
module sc_ctrl_alu
  import sc_pkg::*;
(
  input  logic [1:0] alu_class,
  input  logic [5:0] funct,
  output logic [2:0] alu_op
);
  always_comb begin
    case (alu_class)
      CLS_ADD: alu_op = ALU_ADD;
      CLS_SUB: alu_op = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NR   = 32,
  localparam int AW  = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst) regs[g] <= '0;
        else if (we && (waddr == AW'(g))) regs[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_calc(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              load_to_dmem,
  input  logic [MEM_AW-1:0] load_idx,
  input  logic [31:0]       load_data,
  input  logic [MEM_AW-1:0] peek_idx,
  output logic [31:0]       peek_data,
  output logic [31:0]       pc_out,
  output logic [31:0]       instr_out,
  output logic              wb_en,
  output logic [4:0]        wb_reg,
  output logic [31:0]       wb_data,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata
);
  logic [XLEN-1:0] imem [DEPTH];
  logic [XLEN-1:0] dmem [DEPTH];

  logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, pc_next;
  logic [XLEN-1:0] instr;
  logic [5:0]      opcode, funct;
  logic [RIDX-1:0] rs, rt, rd, dest;
  logic [XLEN-1:0] imm_sext;
  ctrl_t           ctrl;
  logic [2:0]      alu_op;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, ld_word, wr_val;
  logic            alu_zero, taken, reg_we, store_we;
  logic [MEM_AW-1:0] daddr;

  // fetch and field split
  assign instr    = imem[pc_q[MEM_AW+1:2]];
  assign opcode   = instr[31:26];
  assign rs       = instr[25:21];
  assign rt       = instr[20:16];
  assign rd       = instr[15:11];
  assign funct    = instr[5:0];
  assign imm_sext = sext16(instr[15:0]);

  sc_ctrl_main u_main (.opcode(opcode), .ctrl(ctrl));
  sc_ctrl_alu  u_aluc (.alu_class(ctrl.alu_class), .funct(funct), .alu_op(alu_op));

  assign dest   = ctrl.dst_is_rd ? rd : rt;
  assign reg_we = ctrl.reg_write && !rst;

  sc_regfile #(.W(XLEN), .NR(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(dest), .wdata(wr_val),
    .raddr_a(rs), .raddr_b(rt), .rdata_a(rs_val), .rdata_b(rt_val)
  );

  assign alu_b = ctrl.b_is_imm ? imm_sext : rt_val;

  sc_alu u_alu (.op(alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero));

  // data memory
  assign daddr    = alu_y[MEM_AW+1:2];
  assign ld_word  = dmem[daddr];
  assign store_we = ctrl.mem_write && !rst;
  assign wr_val   = ctrl.wb_from_mem ? ld_word : alu_y;

  always_ff @(posedge clk) begin
    if (load_en && load_to_dmem) dmem[load_idx] <= load_data;
    else if (store_we) dmem[daddr] <= rt_val;
  end

  always_ff @(posedge clk) begin
    if (load_en && !load_to_dmem) imem[load_idx] <= load_data;
  end

  // next PC
  assign taken    = ctrl.branch && alu_zero;
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = branch_target(pc_plus4, imm_sext);
  assign pc_next  = taken ? br_tgt : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else pc_q <= pc_next;
  end

  assign peek_data = dmem[peek_idx];
  assign pc_out    = pc_q;
  assign instr_out = instr;
  assign wb_en     = reg_we && (dest != '0);
  assign wb_reg    = dest;
  assign wb_data   = wr_val;
  assign mem_we    = store_we;
  assign mem_addr  = alu_y;
  assign mem_wdata = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        taken,
  input logic [31:0] imm_sext,
  input logic [4:0]  rs,
  input logic [31:0] rs_val,
  input logic        known,
  input logic        is_rtype,
  input logic        is_load,
  input logic        is_store,
  input logic        is_beq,
  input logic        wb_en,
  input logic        mem_we
);
  // R2 R7: sequential PC steps by 4
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !taken |=> (pc == $past(pc) + 32'd4));

  // R5: taken branch reaches target
  assert_branch_target_R5: assert property (@(posedge clk) disable iff (rst)
    taken |=> (pc == $past(pc) + 32'd4 + {$past(imm_sext[29:0]), 2'b00}));

  // R6: register 0 always reads zero
  assert_r0_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rs == 5'd0) |-> (rs_val == 32'd0));

  // R7: unknown opcodes write nothing
  assert_noop_R7: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!wb_en && !mem_we));

  // R4 R5: stores and branches write no register
  assert_no_wb_R4: assert property (@(posedge clk) disable iff (rst)
    (is_store || is_beq) |-> !wb_en);

  // R5: branch never stores
  assert_beq_nostore_R5: assert property (@(posedge clk) disable iff (rst)
    is_beq |-> !mem_we);

  // R9: at most one instruction class decoded
  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_rtype, is_load, is_store, is_beq}));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc_q), .taken(taken), .imm_sext(imm_sext),
  .rs(rs), .rs_val(rs_val), .known(ctrl.known),
  .is_rtype(ctrl.dst_is_rd), .is_load(ctrl.mem_read),
  .is_store(ctrl.mem_write), .is_beq(ctrl.branch),
  .wb_en(wb_en), .mem_we(mem_we)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0, load_to_dmem = 1'b0;
  logic [AW-1:0] load_idx = '0, peek_idx = '0;
  logic [31:0] load_data = '0;
  logic [31:0] peek_data, pc_out, instr_out, wb_data, mem_addr, mem_wdata;
  logic wb_en, mem_we;
  logic [4:0] wb_reg;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_core #(.MEM_AW(AW)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_to_dmem(load_to_dmem),
    .load_idx(load_idx), .load_data(load_data), .peek_idx(peek_idx),
    .peek_data(peek_data), .pc_out(pc_out), .instr_out(instr_out),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [5:0]  fn;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0005, 32'h0000_0007, 6'h20, 32'h0000_000C},
    '{32'h0000_0005, 32'h0000_0007, 6'h22, 32'hFFFF_FFFE},
    '{32'hF0F0_1234, 32'h0FF0_FFFF, 6'h24, 32'h00F0_1234},
    '{32'hF000_0000, 32'h0000_000F, 6'h25, 32'hF000_000F},
    '{32'hFFFF_FFFF, 32'h0000_0001, 6'h2A, 32'h0000_0001},
    '{32'h0000_0001, 32'hFFFF_FFFF, 6'h2A, 32'h0000_0000},
    '{32'h7FFF_FFFF, 32'h0000_0001, 6'h20, 32'h8000_0000},
    '{32'h0000_0009, 32'h0000_0009, 6'h22, 32'h0000_0000},
    '{32'h8000_0000, 32'h7FFF_FFFF, 6'h2A, 32'h0000_0001}
  };

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic load_word(input bit to_d, input int idx, input logic [31:0] w);
    load_en = 1'b1; load_to_dmem = to_d; load_idx = AW'(idx); load_data = w;
    @(posedge clk); @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic enter_reset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic peek(input int idx, output logic [31:0] v);
    peek_idx = AW'(idx);
    #1 v = peek_data;
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk);

    // R1: reset state and register clearing
    enter_reset();
    check("R1 pc in reset", pc_out, 32'd0);
    load_word(1, 3, 32'h0000_DEAD);
    load_word(0, 0, enc_i(6'h2B, 0, 5, 12));
    load_word(0, 1, 32'hFC00_0000);
    rst = 1'b0;
    check("R1 pc after release", pc_out, 32'd0);
    step();
    peek(3, v);
    check("R1 register cleared", v, 32'd0);

    // R2: vector table of register operations
    for (int i = 0; i < NV; i++) begin
      enter_reset();
      load_word(1, 0, VECS[i].a);
      load_word(1, 1, VECS[i].b);
      load_word(0, 0, enc_i(6'h23, 0, 1, 0));
      load_word(0, 1, enc_i(6'h23, 0, 2, 4));
      load_word(0, 2, enc_r(1, 2, 3, VECS[i].fn));
      load_word(0, 3, enc_i(6'h2B, 0, 3, 8));
      rst = 1'b0;
      step(); step();
      check("R9 wb_en on R-type", {31'd0, wb_en}, 32'd1);
      check("R9 wb_reg on R-type", {27'd0, wb_reg}, 32'd3);
      step(); step();
      peek(2, v);
      check($sformatf("R2 vector %0d", i), v, VECS[i].exp);
      check("R2 pc advance", pc_out, 32'd16);
    end

    // R3 R4 R6 R7 R8: memory, zero register, no-op
    enter_reset();
    load_word(1, 2, 32'h0000_0014);
    load_word(1, 4, 32'hCAFE_BABE);
    load_word(1, 9, 32'h1111_1111);
    load_word(0, 0, enc_i(6'h23, 0, 1, 8));
    load_word(0, 1, enc_i(6'h23, 1, 2, -4));
    load_word(0, 2, enc_i(6'h2B, 1, 2, 12));
    load_word(0, 3, enc_r(2, 2, 0, 6'h20));
    load_word(0, 4, enc_i(6'h2B, 0, 0, 36));
    load_word(0, 5, enc_r(1, 1, 1, 6'h20));
    load_word(0, 6, enc_i(6'h2B, 0, 1, 40));
    load_word(0, 7, 32'hFC21_0000);
    load_word(0, 8, enc_i(6'h2B, 0, 1, 44));
    rst = 1'b0;
    for (int k = 0; k < 9; k++) begin
      if (pc_out == 32'd8) begin
        check("R4 store no wb", {31'd0, wb_en}, 32'd0);
        check("R9 store addr", mem_addr, 32'h0000_0020);
      end
      if (pc_out == 32'd12) check("R6 r0 write hidden", {31'd0, wb_en}, 32'd0);
      if (pc_out == 32'd28) check("R7 no-op writes", {30'd0, wb_en, mem_we}, 32'd0);
      step();
    end
    check("R7 pc after no-op", pc_out, 32'd36);
    peek(8, v);  check("R3 load negative offset", v, 32'hCAFE_BABE);
    peek(9, v);  check("R6 r0 reads zero", v, 32'd0);
    peek(10, v); check("R8 same-reg read/write", v, 32'h0000_0028);
    peek(11, v); check("R7 no-op leaves r1", v, 32'h0000_0028);

    // R5: branch trace
    enter_reset();
    load_word(1, 0, 32'd7);
    load_word(1, 1, 32'd7);
    load_word(1, 2, 32'd3);
    load_word(1, 3, 32'h0000_0055);
    load_word(0, 0, enc_i(6'h23, 0, 1, 0));
    load_word(0, 1, enc_i(6'h23, 0, 2, 4));
    load_word(0, 2, enc_i(6'h23, 0, 3, 8));
    load_word(0, 3, enc_i(6'h04, 1, 3, 5));
    load_word(0, 4, enc_i(6'h04, 1, 2, 2));
    load_word(0, 5, enc_i(6'h2B, 0, 1, 12));
    load_word(0, 6, enc_i(6'h2B, 0, 1, 12));
    load_word(0, 7, enc_i(6'h04, 3, 3, 1));
    load_word(0, 8, enc_i(6'h2B, 0, 1, 12));
    load_word(0, 9, enc_i(6'h04, 0, 0, -10));
    rst = 1'b0;
    begin
      logic [31:0] trace [8];
      trace = '{32'd0, 32'd4, 32'd8, 32'd12, 32'd16, 32'd28, 32'd36, 32'd0};
      for (int k = 0; k < 8; k++) begin
        check($sformatf("R5 pc trace step %0d", k), pc_out, trace[k]);
        if (k >= 3 && k <= 6) check("R5 branch writes nothing", {30'd0, wb_en, mem_we}, 32'd0);
        if (k < 7) step();
      end
    end
    peek(3, v);
    check("R5 skipped stores", v, 32'h0000_0055);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule